// File: doc/BRIEF.md
# Inbound Address Translation Window Matcher

This block turns the 34-bit address of a read or write request arriving from a serial fabric into a 32-bit address on the local memory-mapped bus. Software programs a set of windows through a small word-addressed register port. A window is described by a base value, a mask value with an enable flag, an offset value, and two extension bits each for the base and the mask. These extension bits take part in the compare on address bits 33:32. Each request is compared against every enabled window at once. The lowest-numbered window that matches supplies the translated address.

Requests enter on a valid/ready handshake and results leave on a second one, one cycle after acceptance. A small controller has two states. In `ST_IDLE` no result is held. In `ST_FULL` a result is held on the output. Its transitions are:
- **accept**: `ST_IDLE` to `ST_FULL` when a request is taken.
- **stream**: `ST_FULL` to `ST_FULL` when the held result is consumed and a new request is taken in the same cycle.
- **stall**: `ST_FULL` to `ST_FULL` when the held result is not consumed.
- **drain**: `ST_FULL` to `ST_IDLE` when the result is consumed and no request is waiting.

An address that matches no enabled window comes back as a miss. A miss latches a sticky out-of-bounds flag. That flag drives the interrupt output when the interrupt is enabled.

Top module: `inbound_window_xlate`

## Requirements
- R1: After reset, `out_valid`, `out_hit` and `irq` are 0, `in_ready` is 1, and every window register reads 0, so every window is disabled.
- R2: Register word map for window n:
  - Base is at word 4n. Bits 31:4 are stored and bits 3:0 read 0.
  - Mask is at word 4n+1. Bits 31:4 are stored, bit 0 is the enable flag, and bits 3:1 read 0.
  - Offset is at word 4n+2. Bits 31:4 are stored and bits 3:0 read 0.
  - The extension register is at word 4n+3. Bits 1:0 are the base extension, bits 3:2 are the mask extension, and bits 31:4 read 0.
  - The status register is at word 4*NWIN. Its bit 0 is the out-of-bounds flag.
  - The interrupt enable is at word 4*NWIN+1, bit 0.
  - `reg_rdata` follows `reg_addr` combinationally.
- R3: A window whose enable flag is 0 never matches.
- R4: An enabled window matches when `(addr[33:4] & {mext, mask[31:4]}) == ({bext, base[31:4]} & {mext, mask[31:4]})`. Address bits 3:0 never affect the match.
- R5: When several enabled windows match, `out_win` reports the lowest-numbered one, and that window's offset is used.
- R6: On a hit, `out_addr[31:4]` = `(addr[31:4] & ~mask) | (offset & mask)` and `out_addr[3:0]` = `addr[3:0]`.
- R7: A request taken on a clock edge where `in_valid && in_ready` shows its result with `out_valid` = 1 after that edge.
  - `in_ready` equals `!out_valid || out_ready`.
  - While `out_valid && !out_ready`, every result output holds steady.
- R8: On a miss, `out_hit` = 0, `out_win` = 0 and `out_addr` = `addr[31:0]`, and the out-of-bounds flag is set.
- R9: The out-of-bounds flag stays set until a write with data bit 0 = 1 to the status register. Writing 0 leaves it unchanged. A miss in the same cycle as the clearing write leaves it set.
- R10: `irq` is 1 exactly when the out-of-bounds flag and the interrupt enable bit are both 1.
- R11: A register write made while a result is held does not change that result. It applies to requests accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request may be taken |
| in_addr | input | 34 | Incoming fabric address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| out_addr | output | 32 | Translated local address |
| out_hit | output | 1 | 1 when a window matched |
| out_win | output | WIN_IDX_W | Index of the matching window |
| irq | output | 1 | Out-of-bounds interrupt |

## Verification
The hardest conditions to reach from the ports involve a held result:
- a result kept under back-pressure while a new request waits;
- a window register rewritten while its result is still held;
- a clearing write to the status flag landing in the very cycle a miss is accepted.

The bench reaches each of these in its own task. It holds `out_ready` low across several cycles, and it queues the second request and the register write during that hold. For the last case it drives the write strobe and a missing request at the same falling edge. Overlapping windows with different masks and extension bits exercise the priority and the 34-bit compare.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int FAB_AW = 34;
    localparam int LOC_AW = 32;
    localparam int CMP_W  = 28;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FULL = 1'b1
    } xl_state_e;

    typedef struct packed {
        logic [CMP_W-1:0] base;
        logic [CMP_W-1:0] mask;
        logic             en;
        logic [CMP_W-1:0] offs;
        logic [1:0]       bext;
        logic [1:0]       mext;
    } win_cfg_t;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
    import xlate_pkg::*;
#(
    parameter int NWIN   = 4,
    parameter int REG_AW = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [REG_AW-1:0]      addr,
    input  logic [31:0]            wdata,
    input  logic                   miss_set,
    output win_cfg_t [NWIN-1:0]    cfg,
    output logic [31:0]            rdata,
    output logic                   irq
);
    localparam logic [REG_AW-1:0] STAT_A = REG_AW'(4 * NWIN);
    localparam logic [REG_AW-1:0] IREN_A = REG_AW'(4 * NWIN + 1);

    logic stat_q;
    logic iren_q;
    logic clr_req;

    assign clr_req = we && (addr == STAT_A) && wdata[0];

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [REG_AW-1:0] WB = REG_AW'(4 * g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[g] <= '0;
            end else if (we) begin
                if (addr == WB)
                    cfg[g].base <= wdata[31:4];
                if (addr == WB + REG_AW'(1)) begin
                    cfg[g].mask <= wdata[31:4];
                    cfg[g].en   <= wdata[0];
                end
                if (addr == WB + REG_AW'(2))
                    cfg[g].offs <= wdata[31:4];
                if (addr == WB + REG_AW'(3)) begin
                    cfg[g].bext <= wdata[1:0];
                    cfg[g].mext <= wdata[3:2];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
            iren_q <= 1'b0;
        end else begin
            stat_q <= miss_set | (stat_q & ~clr_req);
            if (we && addr == IREN_A)
                iren_q <= wdata[0];
        end
    end

    assign irq = stat_q & iren_q;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (addr == REG_AW'(4 * i))
                rdata = {cfg[i].base, 4'b0};
            if (addr == REG_AW'(4 * i + 1))
                rdata = {cfg[i].mask, 3'b0, cfg[i].en};
            if (addr == REG_AW'(4 * i + 2))
                rdata = {cfg[i].offs, 4'b0};
            if (addr == REG_AW'(4 * i + 3))
                rdata = {28'b0, cfg[i].mext, cfg[i].bext};
        end
        if (addr == STAT_A)
            rdata = {31'b0, stat_q};
        if (addr == IREN_A)
            rdata = {31'b0, iren_q};
    end

    // R9: a miss always leaves the flag set on the next cycle
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        miss_set |=> stat_q);

    // R9: without a clearing write the flag stays set
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !clr_req) |=> stat_q);

    // R10: irq only while the enable bit is set
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == IREN_A && !wdata[0]) |=> !irq);
endmodule

// File: rtl/xlate_match.sv
module xlate_match
    import xlate_pkg::*;
#(
    parameter int NWIN      = 4,
    parameter int WIN_IDX_W = 2
) (
    input  win_cfg_t [NWIN-1:0]    cfg,
    input  logic [FAB_AW-1:0]      addr,
    output logic                   hit,
    output logic [WIN_IDX_W-1:0]   win,
    output logic [LOC_AW-1:0]      xaddr
);
    localparam int CW = CMP_W + 2;

    logic [NWIN-1:0]         hv;
    logic [NWIN-1:0][CW-1:0] mfull;
    logic [NWIN-1:0][CW-1:0] bfull;
    logic [CW-1:0]           acmp;

    assign acmp = addr[FAB_AW-1:4];

    for (genvar g = 0; g < NWIN; g++) begin : g_cmp
        assign mfull[g] = {cfg[g].mext, cfg[g].mask};
        assign bfull[g] = {cfg[g].bext, cfg[g].base};
        assign hv[g]    = cfg[g].en && ((acmp & mfull[g]) == (bfull[g] & mfull[g]));
    end

    always_comb begin
        hit   = 1'b0;
        win   = '0;
        xaddr = addr[LOC_AW-1:0];
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit   = 1'b1;
                win   = WIN_IDX_W'(i);
                xaddr = {(addr[LOC_AW-1:4] & ~cfg[i].mask) | (cfg[i].offs & cfg[i].mask),
                         addr[3:0]};
            end
        end
    end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
    import xlate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    xl_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (in_valid) st_d = ST_FULL;
            ST_FULL: if (out_ready && !in_valid) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
        endcase
        load = in_valid && in_ready;
    end

    // R7: a result not yet consumed stays presented
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    // R7: an accepted request is presented on the next cycle
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out_valid);
endmodule

// File: rtl/inbound_window_xlate.sv
module inbound_window_xlate
    import xlate_pkg::*;
#(
    parameter int NWIN      = 4,
    parameter int WIN_IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1,
    parameter int REG_AW    = $clog2(4 * NWIN + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [33:0]           in_addr,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [31:0]           out_addr,
    output logic                  out_hit,
    output logic [WIN_IDX_W-1:0]  out_win,
    output logic                  irq
);
    win_cfg_t [NWIN-1:0]  cfg;
    logic                 m_hit;
    logic [WIN_IDX_W-1:0] m_win;
    logic [LOC_AW-1:0]    m_addr;
    logic                 load;

    xlate_regs #(.NWIN(NWIN), .REG_AW(REG_AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .miss_set (load && !m_hit),
        .cfg      (cfg),
        .rdata    (reg_rdata),
        .irq      (irq)
    );

    xlate_match #(.NWIN(NWIN), .WIN_IDX_W(WIN_IDX_W)) u_match (
        .cfg   (cfg),
        .addr  (in_addr),
        .hit   (m_hit),
        .win   (m_win),
        .xaddr (m_addr)
    );

    xlate_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_hit  <= 1'b0;
            out_win  <= '0;
        end else if (load) begin
            out_addr <= m_addr;
            out_hit  <= m_hit;
            out_win  <= m_win;
        end
    end

    // R7: held results do not move under back-pressure
    a_r7_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_addr) && $stable(out_hit) && $stable(out_win)));

    // R8: a miss is reported with window 0 and the raw low address
    a_r8_miss_result: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !m_hit) |=> (!out_hit && out_win == '0 && out_addr == $past(in_addr[31:0])));

    // R11: a register write during a hold leaves the held result alone
    a_r11_held_write: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && reg_we) |=> $stable(out_addr));
endmodule

// File: tb/inbound_window_xlate_test.sv
module inbound_window_xlate_test;
    localparam int NWIN = 4;
    localparam int WIW  = 2;
    localparam int RAW  = 5;
    localparam logic [RAW-1:0] STAT = RAW'(4 * NWIN);
    localparam logic [RAW-1:0] IREN = RAW'(4 * NWIN + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [33:0] in_addr = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [31:0] out_addr;
    logic out_hit;
    logic [WIW-1:0] out_win;
    logic irq;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_base [NWIN];
    logic [31:0] m_mask [NWIN];
    logic [31:0] m_offs [NWIN];
    logic [3:0]  m_ext  [NWIN];

    always #5 clk = ~clk;

    inbound_window_xlate #(.NWIN(NWIN)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_addr(in_addr), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_hit(out_hit),
        .out_win(out_win), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [RAW-1:0] a, input logic [31:0] d);
        int w;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        w = int'(a) / 4;
        if (w < NWIN) begin
            case (a % 4)
                0: m_base[w] = {d[31:4], 4'b0};
                1: m_mask[w] = {d[31:4], 3'b0, d[0]};
                2: m_offs[w] = {d[31:4], 4'b0};
                default: m_ext[w] = d[3:0];
            endcase
        end
    endtask

    task automatic rd(input logic [RAW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic void model(input logic [33:0] a, output logic h,
                                  output logic [WIW-1:0] w, output logic [31:0] o);
        h = 1'b0; w = '0; o = a[31:0];
        for (int i = NWIN - 1; i >= 0; i--) begin
            logic [29:0] m;
            logic [29:0] b;
            m = {m_ext[i][3:2], m_mask[i][31:4]};
            b = {m_ext[i][1:0], m_base[i][31:4]};
            if (m_mask[i][0] && ((a[33:4] & m) == (b & m))) begin
                h = 1'b1; w = WIW'(i);
                o = {(a[31:4] & ~m_mask[i][31:4]) | (m_offs[i][31:4] & m_mask[i][31:4]), a[3:0]};
            end
        end
    endfunction

    task automatic lookup_chk(input string req, input logic [33:0] a);
        logic h; logic [WIW-1:0] w; logic [31:0] o;
        model(a, h, w, o);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " hit"}, 64'(out_hit), 64'(h));
        chk({req, " win"}, 64'(out_win), 64'(w));
        chk({req, " addr"}, 64'(out_addr), 64'(o));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 out_hit", 64'(out_hit), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        for (int i = 0; i < NWIN; i++) begin
            rd(RAW'(4 * i + 1), d);
            chk("R1 mask reset", 64'(d), 64'd0);
        end
        lookup_chk("R1 R3 all disabled miss", 34'h0_0000_0000);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(5'd0, 32'hFFFF_FFFF); rd(5'd0, d); chk("R2 base rsvd", 64'(d), 64'hFFFF_FFF0);
        wr(5'd1, 32'hFFFF_FFFE); rd(5'd1, d); chk("R2 mask rsvd", 64'(d), 64'hFFFF_FFF0);
        wr(5'd2, 32'hFFFF_FFFF); rd(5'd2, d); chk("R2 offs rsvd", 64'(d), 64'hFFFF_FFF0);
        wr(5'd3, 32'hFFFF_FFFF); rd(5'd3, d); chk("R2 ext rsvd", 64'(d), 64'h0000_000F);
        wr(5'd0, 32'h0); wr(5'd2, 32'h0); wr(5'd3, 32'h0);
        wr(IREN, 32'h1); rd(IREN, d); chk("R2 irq enable", 64'(d), 64'd1);
        wr(IREN, 32'h0);
        wr(STAT, 32'h1);
    endtask

    task automatic t_basic();
        wr(5'd4, 32'h1000_0000);
        wr(5'd5, 32'hF000_0001);
        wr(5'd6, 32'h2000_0000);
        wr(5'd7, 32'h0000_000C);
        lookup_chk("R4 R6 basic hit", 34'h0_1234_5678);
        lookup_chk("R4 R6 low bits pass", 34'h0_1234_567F);
        lookup_chk("R4 ext bits miss", 34'h1_1234_5678);
        wr(STAT, 32'h1);
    endtask

    task automatic t_priority();
        wr(5'd0, 32'h1200_0000);
        wr(5'd1, 32'hFF00_0001);
        wr(5'd2, 32'h4000_0000);
        wr(5'd3, 32'h0000_000C);
        lookup_chk("R5 overlap lowest wins", 34'h0_1234_5678);
        lookup_chk("R5 only win1", 34'h0_1334_5678);
        wr(5'd1, 32'hFF00_0000);
        lookup_chk("R3 disabled window skipped", 34'h0_1234_5678);
    endtask

    task automatic t_miss_irq();
        logic [31:0] d;
        wr(STAT, 32'h1);
        lookup_chk("R8 miss no irq", 34'h0_8000_0010);
        rd(STAT, d); chk("R8 status set", 64'(d), 64'd1);
        chk("R10 irq masked", 64'(irq), 64'd0);
        wr(IREN, 32'h1);
        #1 chk("R10 irq raised", 64'(irq), 64'd1);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(STAT, 32'h0); rd(STAT, d); chk("R9 write 0 no clear", 64'(d), 64'd1);
        wr(STAT, 32'h1); rd(STAT, d); chk("R9 w1c clears", 64'(d), 64'd0);
        chk("R10 irq low after clear", 64'(irq), 64'd0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = STAT; reg_wdata = 32'h1;
        in_valid = 1'b1; in_addr = 34'h0_9000_0000; out_ready = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
        chk("R8 miss hit flag", 64'(out_hit), 64'd0);
        rd(STAT, d); chk("R9 set beats clear", 64'(d), 64'd1);
        chk("R10 irq with set", 64'(irq), 64'd1);
        wr(STAT, 32'h1);
    endtask

    task automatic t_backpressure();
        logic h; logic [WIW-1:0] w; logic [31:0] oa, ob;
        model(34'h0_1334_5678, h, w, oa);
        model(34'h0_1234_0001, h, w, ob);
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_addr = 34'h0_1334_5678;
        @(negedge clk);
        chk("R7 valid after accept", 64'(out_valid), 64'd1);
        chk("R7 ready low on hold", 64'(in_ready), 64'd0);
        in_addr = 34'h0_1234_0001;
        repeat (2) begin
            @(negedge clk);
            chk("R7 held addr", 64'(out_addr), 64'(oa));
            chk("R7 held valid", 64'(out_valid), 64'd1);
        end
        out_ready = 1'b1;
        #1 chk("R7 ready follows out_ready", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 streamed result", 64'(out_addr), 64'(ob));
        chk("R7 streamed valid", 64'(out_valid), 64'd1);
        @(negedge clk);
        chk("R7 drained", 64'(out_valid), 64'd0);
    endtask

    task automatic t_inflight();
        logic [31:0] d;
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_addr = 34'h0_1334_5678;
        @(negedge clk);
        in_valid = 1'b0;
        wr(5'd5, 32'hF000_0000);
        chk("R11 held hit", 64'(out_hit), 64'd1);
        chk("R11 held addr", 64'(out_addr), 64'h2334_5678);
        out_ready = 1'b1;
        @(negedge clk);
        lookup_chk("R11 next request sees write", 34'h0_1334_5678);
        rd(STAT, d); chk("R11 miss flagged", 64'(d), 64'd1);
    endtask

    initial begin
        for (int i = 0; i < NWIN; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_offs[i] = '0; m_ext[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_basic();
        t_priority();
        t_miss_irq();
        t_w1c();
        t_backpressure();
        t_inflight();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule